// File: doc/BRIEF.md
# Pause-Gated Pulse-Width Generator

This block produces a continuous rectangular wave whose high and low durations are each given as a number of timebase ticks. The timebase is either every clock cycle or one tick per 200 clock cycles, chosen by a single select pin. It is intended for driving an actuator with a fixed duty cycle while letting a separate control signal hold the wave back, for example to let one actuator wait for another.

A hold input gates the wave. The level of that input that lets the wave through is set by a configuration pin. While the hold input is at the other level, the output sits at a configurable rest level and all internal counting freezes. When the wave is let through again, it continues from the exact point inside the phase where it stopped. Duration values may be rewritten while the wave runs. A new value is taken up only when the phase it governs next begins. Durations below two ticks are raised to two.

Top module: `pwm_pause_gen`

## Requirements
- R1: While `enable` is low (and after reset) the output equals `rest_level`, `running` is low, and the wave is rewound: the next enable starts with a full high phase using the current `high_ticks`, and a fresh timebase divider.
- R2: With `slow_tb` = 0, one tick is one clock cycle: after `enable` rises, the output is 1 for `high_ticks` cycles, then 0 for `low_ticks` cycles, and this repeats.
- R3: With `slow_tb` = 1, one tick is 200 clock cycles of running time, so each phase lasts 200 times its tick count in cycles.
- R4: The wave reaches `pwm_out` only while `hold_in` equals `pass_level`. Otherwise `pwm_out` equals `rest_level`.
- R5: `pass_level` = 1 passes the wave while `hold_in` is high. `pass_level` = 0 passes it while `hold_in` is low.
- R6: While held, the phase, the elapsed tick count and the timebase divider keep their values, so the wave resumes mid-phase with the remaining time intact.
- R7: A new `high_ticks` or `low_ticks` value takes effect only at the next phase boundary. The phase in progress keeps the length it started with.
- R8: A tick count of 0 or 1 is treated as 2. Every phase lasts at least two ticks.
- R9: `running` is 1 exactly when `enable` is 1 and `hold_in` equals `pass_level`.
- R10: The resting output level is chosen by `rest_level` (0 or 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator; low rewinds it |
| high_ticks | input | 24 | High phase length in ticks |
| low_ticks | input | 24 | Low phase length in ticks |
| slow_tb | input | 1 | 0: tick every cycle; 1: tick every 200 cycles |
| pass_level | input | 1 | Level of `hold_in` that lets the wave through |
| rest_level | input | 1 | Output level while disabled or held |
| hold_in | input | 1 | Gating input |
| pwm_out | output | 1 | Gated pulse output |
| running | output | 1 | Enabled and not held |

## Verification
The wave is compared cycle by cycle against an independent per-cycle expectation under several patterns. An uninterrupted fast run with unequal phases separates the high and low lengths. Holds placed inside a phase show whether the counter freezes or restarts. Inverted pass and rest levels expose polarity swaps. Duration changes issued mid-phase distinguish boundary-aligned updates from immediate ones. Counts of 0 and 1 test the floor of two ticks. A slow-timebase run with a hold inside it checks the 200-cycle divider and its freeze. A disable issued mid-wave confirms the rewind.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned MIN_PHASE_TICKS = 2;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned SLOW_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic slow_sel,
  output logic tick
);
  generate
    if (SLOW_DIV > 1) begin : g_div
      localparam int unsigned DIV_W = $clog2(SLOW_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);
      logic [DIV_W-1:0] div_q;
      logic             wrap;

      assign wrap = (div_q == DIV_LAST);
      assign tick = adv && (!slow_sel || wrap);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 div_q <= '0;
        else if (clr)               div_q <= '0;
        else if (adv && slow_sel)   div_q <= wrap ? '0 : div_q + DIV_W'(1);
      end

      // R3: divider stays inside its modulus
      assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DIV_LAST);

      // R6: divider frozen while not advancing
      assert_div_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(div_q));
    end else begin : g_nodiv
      assign tick = adv;
    end
  endgenerate
endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             tick,
  input  logic [CNT_W-1:0] high_ticks,
  input  logic [CNT_W-1:0] low_ticks,
  output phase_e           phase
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_PHASE_TICKS);

  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] high_len;
  logic [CNT_W-1:0] low_len;
  logic             last_tick;
  phase_e           phase_q;

  assign high_len  = (high_ticks < MIN_LEN) ? MIN_LEN : high_ticks;
  assign low_len   = (low_ticks  < MIN_LEN) ? MIN_LEN : low_ticks;
  assign last_tick = (elapsed_q == len_q - CNT_W'(1));
  assign phase     = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_HIGH;
      elapsed_q <= '0;
      len_q     <= MIN_LEN;
    end else if (clr) begin
      phase_q   <= PH_HIGH;
      elapsed_q <= '0;
      len_q     <= high_len;
    end else if (tick) begin
      if (last_tick) begin
        elapsed_q <= '0;
        if (phase_q == PH_HIGH) begin
          phase_q <= PH_LOW;
          len_q   <= low_len;
        end else begin
          phase_q <= PH_HIGH;
          len_q   <= high_len;
        end
      end else begin
        elapsed_q <= elapsed_q + CNT_W'(1);
      end
    end
  end

  // R8: no phase is ever shorter than the floor
  assert_min_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len_q >= MIN_LEN);

  // R2: elapsed count never reaches the latched length
  assert_elapsed_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed_q < len_q);

  // R6: everything frozen while held
  assert_hold_paused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> ($stable(elapsed_q) && $stable(phase_q) && $stable(len_q)));

  // R7: latched length only moves at a boundary (or while rewound)
  assert_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((len_q != $past(len_q)) && !$past(clr)) |-> $past(tick && last_tick));

  // R1: disable rewinds to the start of a high phase
  assert_rewind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (elapsed_q == '0 && phase_q == PH_HIGH));
endmodule

// File: rtl/pwm_out_gate.sv
module pwm_out_gate
  import pwm_pkg::*;
(
  input  logic   pass,
  input  phase_e phase,
  input  logic   rest_level,
  output logic   pwm_out
);
  always_comb begin
    if (pass) pwm_out = (phase == PH_HIGH);
    else      pwm_out = rest_level;
  end
endmodule

// File: rtl/pwm_pause_gen.sv
module pwm_pause_gen
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned SLOW_DIV = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] high_ticks,
  input  logic [CNT_W-1:0] low_ticks,
  input  logic             slow_tb,
  input  logic             pass_level,
  input  logic             rest_level,
  input  logic             hold_in,
  output logic             pwm_out,
  output logic             running
);
  logic   gate_open;
  logic   tick;
  phase_e phase;

  assign gate_open = (hold_in == pass_level);
  assign running   = enable && gate_open;

  pwm_tick_gen #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!enable),
    .adv      (running),
    .slow_sel (slow_tb),
    .tick     (tick)
  );

  pwm_phase_ctr #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!enable),
    .adv        (running),
    .tick       (tick),
    .high_ticks (high_ticks),
    .low_ticks  (low_ticks),
    .phase      (phase)
  );

  pwm_out_gate u_gate (
    .pass       (running),
    .phase      (phase),
    .rest_level (rest_level),
    .pwm_out    (pwm_out)
  );

  // R4: a stopped generator shows the rest level on the pin
  assert_rest_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_out == rest_level));

  // R9: ticks only arrive while running
  assert_tick_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> running);
endmodule

// File: tb/pwm_pause_gen_test.sv
`timescale 1ns/1ps
module pwm_pause_gen_test;
  localparam int CNT_W = 24;
  localparam int DIV   = 200;

  typedef struct {
    logic  pwm;
    logic  run;
    string tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic [CNT_W-1:0] high_ticks = 24'd3;
  logic [CNT_W-1:0] low_ticks = 24'd2;
  logic             slow_tb = 1'b0;
  logic             pass_level = 1'b1;
  logic             rest_level = 1'b0;
  logic             hold_in = 1'b1;
  logic             pwm_out;
  logic             running;

  int compared = 0;
  int mismatched = 0;
  item_t exp_q[$];

  // model state built from the requirements
  int m_ph = 1, m_el = 0, m_len = 2, m_dv = 0;

  always #2.5 clk = ~clk;

  pwm_pause_gen #(.CNT_W(CNT_W), .SLOW_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .high_ticks(high_ticks), .low_ticks(low_ticks),
    .slow_tb(slow_tb), .pass_level(pass_level), .rest_level(rest_level),
    .hold_in(hold_in), .pwm_out(pwm_out), .running(running)
  );

  function automatic int floor2(input logic [CNT_W-1:0] v);
    return (v < 2) ? 2 : int'(v);
  endfunction

  // Driver: pushes expected per cycle, advances model at the edge.
  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      logic act;
      act = enable && (hold_in == pass_level);
      it.pwm = act ? logic'(m_ph) : rest_level;
      it.run = act;
      it.tag = tag;
      exp_q.push_back(it);
      @(posedge clk);
      if (!enable) begin
        m_ph = 1; m_el = 0; m_len = floor2(high_ticks); m_dv = 0;
      end else if (act) begin
        bit tk;
        if (slow_tb) begin
          tk = (m_dv == DIV - 1);
          m_dv = tk ? 0 : m_dv + 1;
        end else tk = 1;
        if (tk) begin
          if (m_el == m_len - 1) begin
            m_el = 0;
            m_ph = 1 - m_ph;
            m_len = m_ph ? floor2(high_ticks) : floor2(low_ticks);
          end else m_el++;
        end
      end
      #1;
    end
  endtask

  // Monitor: compares at the falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      compared++;
      if (pwm_out !== it.pwm || running !== it.run) begin
        mismatched++;
        $display("FAIL %s t=%0t pwm_out/running actual %b/%b expected %b/%b",
                 it.tag, $time, pwm_out, running, it.pwm, it.run);
      end
    end
  end

  initial begin
    #(200000 * 5);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #12;
    // R1: reset state at the pins
    compared++;
    if (pwm_out !== 1'b0 || running !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset pwm/run actual %b/%b expected 0/0", pwm_out, running);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    run(4, "R1");

    // R2: fast run, 3 high / 2 low
    enable = 1'b1;
    run(30, "R2");

    // R4 R6 R9: hold inside a phase, then resume
    hold_in = 1'b0;
    run(7, "R6");
    hold_in = 1'b1;
    run(20, "R4");

    // R1: disable mid-wave rewinds
    enable = 1'b0;
    run(3, "R1");
    // R5 R10: inverted pass level and rest level 1
    pass_level = 1'b0; rest_level = 1'b1; hold_in = 1'b0;
    high_ticks = 24'd4; low_ticks = 24'd5;
    run(2, "R10");
    enable = 1'b1;
    run(13, "R5");
    hold_in = 1'b1;
    run(5, "R10");
    hold_in = 1'b0;
    run(20, "R5");

    // R8: counts 0 and 1 floored to 2
    enable = 1'b0;
    high_ticks = 24'd0; low_ticks = 24'd1;
    run(2, "R8");
    enable = 1'b1;
    run(20, "R8");

    // R7: change lengths mid-phase
    enable = 1'b0;
    high_ticks = 24'd3; low_ticks = 24'd3;
    run(2, "R7");
    enable = 1'b1;
    run(4, "R7");
    high_ticks = 24'd6; low_ticks = 24'd2;
    run(30, "R7");

    // R3: slow timebase with a hold inside it
    enable = 1'b0;
    slow_tb = 1'b1; high_ticks = 24'd2; low_ticks = 24'd3;
    run(2, "R3");
    enable = 1'b1;
    run(550, "R3");
    hold_in = 1'b1;
    run(60, "R6");
    hold_in = 1'b0;
    run(600, "R3");

    // R9: busy low when disabled
    enable = 1'b0;
    run(5, "R9");

    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk); #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule